// File: doc/BRIEF.md
# Atomic Event Store Guard

This block sits beside a core and a coherent cache. It lets the core run a multi-line atomic event. During the collect phase the core names the cache lines that take part, and the block records them in a small table. The core then issues an interference query. The block answers whether any other agent has already touched one of those lines. The query also opens a guard window, and the window lasts until the core ends the event.

Inside the guard window, every store the core issues is held in a private queue, where no other agent can see it. Coherence snoops to participating lines are settled by priority. A requester that outranks the event is served and breaks the event. Every other requester is refused with a NAK, which lets the event run to completion.

When the core ends the event, one of two things happens:
- **Clean event:** the held stores drain out in program order, one per cycle, and a completion pulse follows.
- **Broken event:** every held store is dropped, and a failure pulse carries a reason code. The core uses it to branch to its failure path outside the event.

Either outcome clears all tracking state, so the next event starts fresh.

Top module: `atom_guard`

## Requirements
- R1: After reset, all of these outputs are low and `fail_code` is 0: `wr_valid`, `done`, `fail_valid`, `snp_rsp_valid`, `qry_rsp_valid`.
- R2: An event tracks up to LINES distinct lines. Registering a line that is already held adds no entry. Registering one more distinct line than LINES makes the event fail with code 2.
- R3: A query accepted in the collect phase gets `qry_rsp_valid` on the next cycle. `qry_kill` is 1 exactly when a killing snoop was seen before the query. The query moves the event into the guard window.
- R4: Before the guard window opens, a snoop to a participating line is answered with data (`snp_rsp_nak`=0). That event then fails with code 1.
- R5: Inside the guard window, a snoop to a participating line behaves as follows:
  - If `snp_pri` is strictly greater than the event priority, the snoop gets data and the event fails with code 1.
  - Otherwise the snoop gets `snp_rsp_nak`=1 and the event is unaffected.
- R6: A snoop to a line that is not participating always gets data and never changes the outcome of the event.
- R7: Stores held in the guard window never appear on `wr_valid` before the event ends. On a clean end, they are written starting the cycle after the end, one per cycle, in issue order. `done` pulses for one cycle after the last write, or straight after the end if there are no stores.
- R8: A failed event writes nothing. It raises `fail_valid` for one cycle, the cycle after the end, with a nonzero `fail_code`. `fail_code` is 0 whenever `fail_valid` is low.
- R9: A store to a line that was not registered makes the event fail with code 3.
- R10: A store beyond the SQ_DEPTH queue entries makes the event fail with code 4.
- R11: After commit or abort, no line stays registered and no interference is remembered. This holds for both outcomes.
- R12: Every snoop is answered with `snp_rsp_valid` on the next cycle.
- R13: While committed stores drain, a snoop to a participating line is refused with a NAK, whatever its priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pri | input | PW | Event priority, latched at the first registration |
| reg_valid | input | 1 | Register a participating line |
| reg_line | input | AW-LINE_OFS | Line address to register |
| qry_valid | input | 1 | Interference query, opens the guard window |
| qry_rsp_valid | output | 1 | Query answer strobe |
| qry_kill | output | 1 | Interference already seen at the query |
| st_valid | input | 1 | Guarded store request |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| end_valid | input | 1 | End of the event |
| snp_valid | input | 1 | Incoming snoop |
| snp_line | input | AW-LINE_OFS | Snooped line address |
| snp_pri | input | PW | Snoop requester priority |
| snp_rsp_valid | output | 1 | Snoop answer strobe |
| snp_rsp_nak | output | 1 | 1 = NAK, 0 = data supplied |
| wr_valid | output | 1 | Committed store write strobe |
| wr_addr | output | AW | Committed store address |
| wr_data | output | DW | Committed store data |
| done | output | 1 | Commit finished pulse |
| fail_valid | output | 1 | Event failed pulse |
| fail_code | output | 3 | 1 interference, 2 line overflow, 3 unregistered store, 4 store overflow |

## Verification
The assertions assume the core follows the event protocol:
- It registers lines only before the query, queries once, and stores only inside the guard window.
- It raises at most one of `reg_valid`, `qry_valid` and `end_valid` in a cycle.
- The snoop side sends at most one snoop per cycle.

The stimulus drives one request per cycle from tasks that follow this order. It never overlaps a snoop with a query. Priority and table-size corners are reached only by legal sequences of registrations, stores and snoops.

// File: rtl/atom_guard_pkg.sv
package atom_guard_pkg;

  typedef enum logic [2:0] {
    AG_IDLE    = 3'd0,
    AG_COLLECT = 3'd1,
    AG_GUARD   = 3'd2,
    AG_DRAIN   = 3'd3,
    AG_FIN     = 3'd4,
    AG_FAIL    = 3'd5
  } ag_state_e;

  typedef enum logic [2:0] {
    EC_NONE      = 3'd0,
    EC_INTERFERE = 3'd1,
    EC_LINE_OVF  = 3'd2,
    EC_UNREG_ST  = 3'd3,
    EC_STORE_OVF = 3'd4
  } ag_err_e;

  // a snooper wins only when it strictly outranks the event
  function automatic logic snoop_outranks(input logic [15:0] snp, input logic [15:0] ev);
    return snp > ev;
  endfunction

  // the first recorded reason is kept for the whole event
  function automatic ag_err_e keep_first(input ag_err_e cur, input logic hit, input ag_err_e cand);
    return (cur == EC_NONE && hit) ? cand : cur;
  endfunction

endpackage

// File: rtl/ag_line_table.sv
module ag_line_table #(
  parameter int LINES = 8,
  parameter int TW    = 26,
  localparam int CW   = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [TW-1:0] add_tag,
  input  logic [TW-1:0] snp_tag,
  input  logic [TW-1:0] st_tag,
  output logic          add_dup,
  output logic          tbl_full,
  output logic          snp_hit,
  output logic          st_hit,
  output logic [CW-1:0] count
);

  logic [LINES-1:0] add_m;
  logic [LINES-1:0] snp_m;
  logic [LINES-1:0] st_m;

  for (genvar g = 0; g < LINES; g++) begin : g_ent
    logic          v_q;
    logic [TW-1:0] t_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (clr) begin
        v_q <= 1'b0;
      end else if (add_en && count == CW'(g)) begin
        v_q <= 1'b1;
        t_q <= add_tag;
      end
    end

    assign add_m[g] = v_q && (t_q == add_tag);
    assign snp_m[g] = v_q && (t_q == snp_tag);
    assign st_m[g]  = v_q && (t_q == st_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (add_en) count <= count + CW'(1);
  end

  assign add_dup  = |add_m;
  assign snp_hit  = |snp_m;
  assign st_hit   = |st_m;
  assign tbl_full = (count == CW'(LINES));

endmodule

// File: rtl/ag_store_q.sv
module ag_store_q #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic          last,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data
);

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [CW-1:0] wr_ptr;
  logic [CW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wr_ptr[IW-1:0]] <= push_addr;
      data_mem[wr_ptr[IW-1:0]] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + CW'(1);
      if (pop)  rd_ptr <= rd_ptr + CW'(1);
    end
  end

  assign full      = (wr_ptr == CW'(DEPTH));
  assign empty     = (rd_ptr == wr_ptr);
  assign last      = (CW'(rd_ptr + CW'(1)) == wr_ptr);
  assign head_addr = addr_mem[rd_ptr[IW-1:0]];
  assign head_data = data_mem[rd_ptr[IW-1:0]];

endmodule

// File: rtl/ag_ctrl.sv
module ag_ctrl
  import atom_guard_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] ev_pri,
  input  logic          reg_valid,
  input  logic          qry_valid,
  input  logic          st_valid,
  input  logic          end_valid,
  input  logic          snp_valid,
  input  logic [PW-1:0] snp_pri,
  input  logic          snp_hit,
  input  logic          st_hit,
  input  logic          add_dup,
  input  logic          tbl_full,
  input  logic          sq_full,
  input  logic          sq_empty,
  input  logic          sq_last,
  output logic          add_en,
  output logic          push,
  output logic          pop,
  output logic          clr,
  output logic          qry_accept,
  output logic          qry_rsp_valid,
  output logic          qry_kill,
  output logic          snp_rsp_valid,
  output logic          snp_rsp_nak,
  output logic          wr_valid,
  output logic          done,
  output logic          fail_valid,
  output logic [2:0]    fail_code,
  output logic          guard_win,
  output logic          drain_win,
  output logic [PW-1:0] ev_pri_q
);

  ag_state_e state_q, state_d;
  ag_err_e   err_q, err_d;
  logic      kill_q, kill_d;
  logic      reg_accept, st_accept, end_accept;
  logic      line_ovf, st_unreg, st_ovf;
  logic      snp_part, outranks, pre_kill, guard_kill, nak_d;

  always_comb begin
    guard_win  = (state_q == AG_GUARD);
    drain_win  = (state_q == AG_DRAIN);
    reg_accept = reg_valid && (state_q == AG_IDLE || state_q == AG_COLLECT);
    qry_accept = qry_valid && (state_q == AG_COLLECT);
    st_accept  = st_valid && guard_win;
    end_accept = end_valid && guard_win;

    add_en   = reg_accept && !add_dup && !tbl_full;
    line_ovf = reg_accept && !add_dup && tbl_full;
    st_unreg = st_accept && !st_hit;
    st_ovf   = st_accept && st_hit && sq_full;
    push     = st_accept && st_hit && !sq_full;
    pop      = drain_win;
    clr      = (state_q == AG_FIN) || (state_q == AG_FAIL);

    snp_part   = snp_valid && snp_hit;
    outranks   = snoop_outranks(16'(snp_pri), 16'(ev_pri_q));
    pre_kill   = snp_part && (state_q == AG_COLLECT);
    guard_kill = snp_part && guard_win && outranks;
    nak_d      = snp_part && ((guard_win && !outranks) || drain_win);

    kill_d = kill_q || pre_kill || guard_kill;
    err_d  = keep_first(err_q, pre_kill || guard_kill, EC_INTERFERE);
    err_d  = keep_first(err_d, line_ovf, EC_LINE_OVF);
    err_d  = keep_first(err_d, st_unreg, EC_UNREG_ST);
    err_d  = keep_first(err_d, st_ovf, EC_STORE_OVF);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      AG_IDLE:    if (reg_accept) state_d = AG_COLLECT;
      AG_COLLECT: if (qry_accept) state_d = AG_GUARD;
      AG_GUARD: begin
        if (end_accept) begin
          if (err_d != EC_NONE)       state_d = AG_FAIL;
          else if (sq_empty && !push) state_d = AG_FIN;
          else                        state_d = AG_DRAIN;
        end
      end
      AG_DRAIN:   if (sq_last) state_d = AG_FIN;
      AG_FIN:     state_d = AG_IDLE;
      AG_FAIL:    state_d = AG_IDLE;
      default:    state_d = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= AG_IDLE;
      err_q    <= EC_NONE;
      kill_q   <= 1'b0;
      ev_pri_q <= '0;
    end else begin
      state_q <= state_d;
      if (clr) begin
        err_q  <= EC_NONE;
        kill_q <= 1'b0;
      end else begin
        err_q  <= err_d;
        kill_q <= kill_d;
      end
      if (state_q == AG_IDLE && reg_accept) ev_pri_q <= ev_pri;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qry_rsp_valid <= 1'b0;
      qry_kill      <= 1'b0;
      snp_rsp_valid <= 1'b0;
      snp_rsp_nak   <= 1'b0;
    end else begin
      qry_rsp_valid <= qry_accept;
      qry_kill      <= qry_accept && kill_d;
      snp_rsp_valid <= snp_valid;
      snp_rsp_nak   <= nak_d;
    end
  end

  assign wr_valid   = drain_win;
  assign done       = (state_q == AG_FIN);
  assign fail_valid = (state_q == AG_FAIL);
  assign fail_code  = (state_q == AG_FAIL) ? 3'(err_q) : 3'(EC_NONE);

endmodule

// File: rtl/atom_guard.sv
module atom_guard #(
  parameter int LINES    = 8,
  parameter int SQ_DEPTH = 8,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LINE_OFS = 6,
  parameter int PW       = 4,
  localparam int TW      = AW - LINE_OFS,
  localparam int LCW     = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] ev_pri,
  input  logic          reg_valid,
  input  logic [TW-1:0] reg_line,
  input  logic          qry_valid,
  output logic          qry_rsp_valid,
  output logic          qry_kill,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          end_valid,
  input  logic          snp_valid,
  input  logic [TW-1:0] snp_line,
  input  logic [PW-1:0] snp_pri,
  output logic          snp_rsp_valid,
  output logic          snp_rsp_nak,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic          fail_valid,
  output logic [2:0]    fail_code
);

  function automatic logic [TW-1:0] line_of(input logic [AW-1:0] a);
    return a[AW-1:LINE_OFS];
  endfunction

  // named internal events, also observed by the bound checker
  logic           add_en, add_dup, tbl_full, snp_hit, st_hit;
  logic           push, pop, clr, sq_full, sq_empty, sq_last;
  logic           qry_accept, guard_win, drain_win;
  logic [LCW-1:0] line_cnt;
  logic [PW-1:0]  ev_pri_q;
  logic [TW-1:0]  st_line;

  assign st_line = line_of(st_addr);

  ag_line_table #(.LINES(LINES), .TW(TW)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .add_en   (add_en),
    .add_tag  (reg_line),
    .snp_tag  (snp_line),
    .st_tag   (st_line),
    .add_dup  (add_dup),
    .tbl_full (tbl_full),
    .snp_hit  (snp_hit),
    .st_hit   (st_hit),
    .count    (line_cnt)
  );

  ag_store_q #(.DEPTH(SQ_DEPTH), .AW(AW), .DW(DW)) u_sq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (pop),
    .full      (sq_full),
    .empty     (sq_empty),
    .last      (sq_last),
    .head_addr (wr_addr),
    .head_data (wr_data)
  );

  ag_ctrl #(.PW(PW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_pri        (ev_pri),
    .reg_valid     (reg_valid),
    .qry_valid     (qry_valid),
    .st_valid      (st_valid),
    .end_valid     (end_valid),
    .snp_valid     (snp_valid),
    .snp_pri       (snp_pri),
    .snp_hit       (snp_hit),
    .st_hit        (st_hit),
    .add_dup       (add_dup),
    .tbl_full      (tbl_full),
    .sq_full       (sq_full),
    .sq_empty      (sq_empty),
    .sq_last       (sq_last),
    .add_en        (add_en),
    .push          (push),
    .pop           (pop),
    .clr           (clr),
    .qry_accept    (qry_accept),
    .qry_rsp_valid (qry_rsp_valid),
    .qry_kill      (qry_kill),
    .snp_rsp_valid (snp_rsp_valid),
    .snp_rsp_nak   (snp_rsp_nak),
    .wr_valid      (wr_valid),
    .done          (done),
    .fail_valid    (fail_valid),
    .fail_code     (fail_code),
    .guard_win     (guard_win),
    .drain_win     (drain_win),
    .ev_pri_q      (ev_pri_q)
  );

endmodule

// File: rtl/ag_checker.sv
module ag_checker #(
  parameter int PW    = 4,
  parameter int LINES = 8,
  parameter int LCW   = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           snp_valid,
  input logic           snp_hit,
  input logic [PW-1:0]  snp_pri,
  input logic [PW-1:0]  ev_pri_q,
  input logic           guard_win,
  input logic           drain_win,
  input logic           qry_accept,
  input logic           qry_rsp_valid,
  input logic           snp_rsp_valid,
  input logic           snp_rsp_nak,
  input logic           wr_valid,
  input logic           done,
  input logic           fail_valid,
  input logic [2:0]     fail_code,
  input logic [LCW-1:0] line_cnt
);

  AST_SNOOP_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_rsp_valid); // R12

  AST_FOREIGN_NO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_hit |=> !snp_rsp_nak); // R6

  AST_EARLY_SNOOP_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_hit && !guard_win && !drain_win |=> !snp_rsp_nak); // R4

  AST_HIGH_PRI_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_hit && guard_win && (snp_pri > ev_pri_q) |=> !snp_rsp_nak); // R5

  AST_LOW_PRI_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_hit && guard_win && (snp_pri <= ev_pri_q) |=> snp_rsp_nak); // R5

  AST_DRAIN_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_hit && drain_win |=> snp_rsp_nak); // R13

  AST_QUERY_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    qry_accept |=> qry_rsp_valid); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= LCW'(LINES)); // R2

  AST_EXCLUSIVE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, done, fail_valid})); // R8

  AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid |-> fail_code != 3'd0); // R8

  AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_valid |-> fail_code == 3'd0); // R8

  AST_DONE_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_valid) |-> done); // R7

endmodule

bind atom_guard ag_checker #(.PW(PW), .LINES(LINES), .LCW(LCW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .snp_valid     (snp_valid),
  .snp_hit       (snp_hit),
  .snp_pri       (snp_pri),
  .ev_pri_q      (ev_pri_q),
  .guard_win     (guard_win),
  .drain_win     (drain_win),
  .qry_accept    (qry_accept),
  .qry_rsp_valid (qry_rsp_valid),
  .snp_rsp_valid (snp_rsp_valid),
  .snp_rsp_nak   (snp_rsp_nak),
  .wr_valid      (wr_valid),
  .done          (done),
  .fail_valid    (fail_valid),
  .fail_code     (fail_code),
  .line_cnt      (line_cnt)
);

// File: tb/sim_atom_guard.sv
module sim_atom_guard;

  localparam int LINES = 8;
  localparam int SQD   = 8;
  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int LOFS  = 4;
  localparam int PW    = 3;
  localparam int TW    = AW - LOFS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] ev_pri = '0;
  logic          reg_valid = 1'b0;
  logic [TW-1:0] reg_line = '0;
  logic          qry_valid = 1'b0;
  logic          qry_rsp_valid, qry_kill;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          end_valid = 1'b0;
  logic          snp_valid = 1'b0;
  logic [TW-1:0] snp_line = '0;
  logic [PW-1:0] snp_pri = '0;
  logic          snp_rsp_valid, snp_rsp_nak;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          done, fail_valid;
  logic [2:0]    fail_code;

  int n_chk = 0;
  int n_fail = 0;
  logic [AW-1:0] exp_addr [SQD];
  logic [DW-1:0] exp_data [SQD];
  int exp_n = 0;

  always #2 clk = ~clk;

  atom_guard #(.LINES(LINES), .SQ_DEPTH(SQD), .AW(AW), .DW(DW), .LINE_OFS(LOFS), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_pri(ev_pri),
    .reg_valid(reg_valid), .reg_line(reg_line),
    .qry_valid(qry_valid), .qry_rsp_valid(qry_rsp_valid), .qry_kill(qry_kill),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .end_valid(end_valid),
    .snp_valid(snp_valid), .snp_line(snp_line), .snp_pri(snp_pri),
    .snp_rsp_valid(snp_rsp_valid), .snp_rsp_nak(snp_rsp_nak),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .fail_valid(fail_valid), .fail_code(fail_code)
  );

  function automatic logic [TW-1:0] line_no(input int k);
    return TW'(k * 5 + 1);
  endfunction

  function automatic logic [AW-1:0] byte_at(input int k, input int ofs);
    return {line_no(k), LOFS'(ofs)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_one(input int k);
    reg_valid = 1'b1;
    reg_line  = line_no(k);
    cyc();
    reg_valid = 1'b0;
  endtask

  task automatic open_event(input int pri, input int nl);
    ev_pri = PW'(pri);
    for (int k = 0; k < nl; k++) reg_one(k);
  endtask

  task automatic query(input bit exp_kill, input string req);
    qry_valid = 1'b1;
    cyc();
    qry_valid = 1'b0;
    chk(qry_rsp_valid == 1'b1, req, int'(qry_rsp_valid), 1);
    chk(qry_kill == exp_kill, req, int'(qry_kill), int'(exp_kill));
  endtask

  task automatic snoop(input logic [TW-1:0] ln, input int pri, input bit exp_nak, input string req);
    snp_valid = 1'b1;
    snp_line  = ln;
    snp_pri   = PW'(pri);
    cyc();
    snp_valid = 1'b0;
    chk(snp_rsp_valid == 1'b1, "R12", int'(snp_rsp_valid), 1);
    chk(snp_rsp_nak == exp_nak, req, int'(snp_rsp_nak), int'(exp_nak));
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit model);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    cyc();
    st_valid = 1'b0;
    chk(wr_valid == 1'b0, "R7 held", int'(wr_valid), 0);
    if (model && exp_n < SQD) begin
      exp_addr[exp_n] = a;
      exp_data[exp_n] = d;
      exp_n++;
    end
  endtask

  task automatic close_ok(input string req);
    end_valid = 1'b1;
    cyc();
    end_valid = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      chk(wr_valid == 1'b1, req, int'(wr_valid), 1);
      chk(wr_addr == exp_addr[i], req, int'(wr_addr), int'(exp_addr[i]));
      chk(wr_data == exp_data[i], req, int'(wr_data), int'(exp_data[i]));
      cyc();
    end
    chk(done == 1'b1, req, int'(done), 1);
    chk(fail_valid == 1'b0, req, int'(fail_valid), 0);
    cyc();
    chk(done == 1'b0 && wr_valid == 1'b0, req, int'({done, wr_valid}), 0);
    exp_n = 0;
  endtask

  task automatic close_fail(input int code, input string req);
    end_valid = 1'b1;
    cyc();
    end_valid = 1'b0;
    chk(fail_valid == 1'b1, req, int'(fail_valid), 1);
    chk(int'(fail_code) == code, req, int'(fail_code), code);
    chk(wr_valid == 1'b0, "R8", int'(wr_valid), 0);
    cyc();
    chk({fail_valid, wr_valid, done} == 3'b000, "R8", int'({fail_valid, wr_valid, done}), 0);
    chk(fail_code == 3'd0, "R8", int'(fail_code), 0);
    exp_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    // R1: reset values
    chk({wr_valid, done, fail_valid, snp_rsp_valid, qry_rsp_valid} == 5'b0, "R1",
        int'({wr_valid, done, fail_valid, snp_rsp_valid, qry_rsp_valid}), 0);
    chk(fail_code == 3'd0, "R1", int'(fail_code), 0);
    rst_n = 1'b1;
    cyc();

    // R7 / R3: sweep of line count and store count, clean events
    for (int nl = 1; nl <= LINES; nl++) begin
      for (int ns = 0; ns <= SQD; ns++) begin
        open_event(2, nl);
        query(1'b0, "R3");
        for (int i = 0; i < ns; i++)
          store(byte_at(i % nl, i), DW'(nl * 256 + i * 17 + 1), 1'b1);
        close_ok("R7");
      end
    end

    // R2: duplicates add nothing, eight distinct lines fit
    ev_pri = 3'd1;
    reg_one(0); reg_one(0); reg_one(0);
    for (int k = 1; k < LINES; k++) reg_one(k);
    query(1'b0, "R2");
    store(byte_at(7, 3), 16'hA5A5, 1'b1);
    close_ok("R2 dedupe");

    // R2: one line too many
    open_event(1, LINES + 1);
    query(1'b0, "R2");
    close_fail(2, "R2 overflow");

    // R4 / R3: interference before the query
    open_event(2, 2);
    snoop(line_no(1), 0, 1'b0, "R4");
    query(1'b1, "R3 kill seen");
    store(byte_at(0, 1), 16'h1111, 1'b1);
    close_fail(1, "R4");

    // R5: priority sweep inside the guard window
    for (int ep = 0; ep < 8; ep++) begin
      for (int sp = 0; sp < 8; sp++) begin
        open_event(ep, 2);
        query(1'b0, "R5");
        store(byte_at(0, sp), DW'(ep * 8 + sp), 1'b1);
        snoop(line_no(1), sp, sp <= ep, "R5");
        if (sp > ep) close_fail(1, "R5 outranked");
        else         close_ok("R5 nak");
      end
    end

    // R6: foreign snoops at top priority change nothing
    open_event(0, 2);
    snoop(line_no(20), 7, 1'b0, "R6");
    query(1'b0, "R6");
    store(byte_at(1, 2), 16'h6666, 1'b1);
    snoop(line_no(21), 7, 1'b0, "R6");
    close_ok("R6");

    // R9: store to an unregistered line
    open_event(3, 2);
    query(1'b0, "R9");
    store(byte_at(0, 0), 16'h9999, 1'b1);
    store(byte_at(30, 0), 16'h9998, 1'b0);
    close_fail(3, "R9");

    // R10: one store beyond the queue
    open_event(3, 1);
    query(1'b0, "R10");
    for (int i = 0; i <= SQD; i++) store(byte_at(0, i), DW'(i), 1'b1);
    close_fail(4, "R10");

    // R13: snoop during the drain is refused
    open_event(0, 2);
    query(1'b0, "R13");
    for (int i = 0; i < 4; i++) store(byte_at(0, i), DW'(16'h100 + i), 1'b1);
    end_valid = 1'b1;
    cyc();
    end_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(wr_valid == 1'b1 && wr_data == exp_data[i], "R13 drain", int'(wr_data), int'(exp_data[i]));
      if (i == 0) begin
        snp_valid = 1'b1;
        snp_line  = line_no(1);
        snp_pri   = 3'd7;
      end
      cyc();
      if (i == 0) begin
        snp_valid = 1'b0;
        chk(snp_rsp_nak == 1'b1, "R13", int'(snp_rsp_nak), 1);
      end
    end
    chk(done == 1'b1, "R13 done", int'(done), 1);
    cyc();
    exp_n = 0;

    // R11: nothing survives a failed event
    open_event(0, 2);
    snoop(line_no(0), 0, 1'b0, "R4");
    query(1'b1, "R11 setup");
    close_fail(1, "R11 setup");
    ev_pri = 3'd0;
    reg_one(40);
    query(1'b0, "R11 kill cleared");
    snoop(line_no(0), 7, 1'b0, "R11 old line gone");
    store(byte_at(40, 5), 16'h4040, 1'b1);
    close_ok("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule